// File: doc/BRIEF.md
# ATA PIO Data Port Engine

A device-side register block that serves programmed-I/O sector transfers through a 16-bit data port. A 256-word (512-byte) sector buffer is walked by a word position pointer. A small task file sits beside it: the sector count, the last command, and a status byte with busy, ready and data-request flags. An interrupt request line completes the set. The host reaches the block through a simple request bus with byte, word and dword accesses at offsets 0 to 7. A separate select reads the alternate status copy.

The media side sees a word-wide port into the same buffer. A one-cycle fetch pulse asks it to load the next sector for a read. A one-cycle commit pulse tells it that a written sector is complete. Disk access time is not modelled. It is replaced by a busy period of a programmable number of cycles, after which the engine hands the buffer back to the host.

Top module: `ata_pio_port`

## Requirements
- R1: While DRQ (status bit 3) is set, a word data access (size_i=1, offset 0) moves the word at the current position and advances the position by one word (2 bytes). Data accesses have no effect while DRQ is clear.
- R2: When the position steps past word 255 it returns to 0. When a busy period follows, BSY (status bit 7) is set and DRQ is cleared for delay_i+1 cycles. Then BSY clears and, for a read, DRQ sets and irq_o asserts.
- R3: A byte write (size_i=0) to the data port stores the byte in both halves of the word, {b,b}.
- R4: A byte read of the data port returns the low byte of the current word and still advances the position by one word.
- R5: With mode32_i=1, a dword (size_i=2) data access moves two words, low half first, and advances by two. With mode32_i=0, the low half is one data word. The high half then acts as a word access at offset 2: it reads {8'h00,count} and loads the count from wdata_i[23:16] on a write.
- R6: With dev_present_i=0, a data read returns 16'hFF7F per word (8'h7F for a byte). Data writes are ignored and the position does not move.
- R7: A word read at offset 7 returns {8'hFF,status}. Status is {BSY,DRDY,0,0,DRQ,0,0,0}, with DRDY = present and not BSY. Any read at offset 7 clears irq_o.
- R8: A read with alt_i=1 returns the status byte and leaves irq_o unchanged.
- R9: Read sector (8'h20) and read multiple (8'hC4) start a busy period. Each sector read out decrements the count, and a count of 0 means 256. After the last sector DRQ clears with no further busy period. Read multiple asserts irq_o only for the first sector of each MULT-sector block.
- R10: Write sector (8'h30) and write multiple (8'hC5) set DRQ at once with no busy period and irq_o low. Each full sector pulses med_commit_o and decrements the count. A busy period followed by irq_o comes after every sector for 8'h30. For 8'hC5 it comes only when a block of MULT sectors completes or the last sector is written.
- R11: Each read busy period begins with a one-cycle med_fetch_o pulse. Words written through the media port are what the host then reads.
- R12: After reset, status is 8'h40 with a device present, irq_o is low, the count is 1 and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_present_i | input | 1 | A device is attached |
| mode32_i | input | 1 | Dword data accesses move two words |
| delay_i | input | DLY_W | Busy period length minus one, in cycles |
| req_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | Host access is a write |
| alt_i | input | 1 | Access targets the alternate status port |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | 0 byte, 1 word, 2 dword |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, combinational |
| irq_o | output | 1 | Interrupt request |
| med_fetch_o | output | 1 | Pulse: load the next sector into the buffer |
| med_commit_o | output | 1 | Pulse: a written sector is ready in the buffer |
| med_addr_i | input | log2(SECTOR_BYTES/2) | Media port word index |
| med_we_i | input | 1 | Media port write |
| med_wdata_i | input | 16 | Media port write data |
| med_rdata_o | output | 16 | Media port read data |

## Verification
A table of mixed write widths fills one sector: duplicated bytes, plain words, words whose upper half must be dropped, and paired dwords. The buffer is then inspected from the media side, which shows whether lane placement and pointer advance agree. Reads of the same sector mix word, byte, paired dword and split dword accesses. The split case returns the sector count in its upper half, which tells it apart from the paired one. Separate runs cover a single-sector flow, a count of zero, an absent device, and the block boundaries of both multiple-sector commands. Each run watches when the busy flag and the interrupt appear or stay silent.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam logic [7:0] CMD_RD      = 8'h20;
  localparam logic [7:0] CMD_RD_MULT = 8'hC4;
  localparam logic [7:0] CMD_WR      = 8'h30;
  localparam logic [7:0] CMD_WR_MULT = 8'hC5;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;

  localparam logic [15:0] ABSENT_WORD = 16'hFF7F;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;
endpackage

// File: rtl/ata_host_decode.sv
module ata_host_decode
  import ata_pio_pkg::*;
(
  input  logic        req_i,
  input  logic        we_i,
  input  logic        alt_i,
  input  logic [2:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic        mode32_i,
  input  logic        present_i,
  input  logic        drq_i,
  output logic        data_acc_o,
  output logic        data_we_o,
  output logic        two_o,
  output logic [1:0]  adv_o,
  output logic [15:0] w0_o,
  output logic [15:0] w1_o,
  output logic        sc_we_o,
  output logic [7:0]  sc_val_o,
  output logic        cmd_we_o,
  output logic [7:0]  cmd_val_o,
  output logic        stat_clr_o
);
  logic sel0, split;

  always_comb begin
    sel0       = req_i & ~alt_i & (addr_i == 3'd0);
    two_o      = size_i[1] & mode32_i;
    split      = sel0 & size_i[1] & ~mode32_i;   // upper half goes to offset 2
    data_acc_o = sel0 & present_i & drq_i;
    data_we_o  = data_acc_o & we_i;
    adv_o      = data_acc_o ? (two_o ? 2'd2 : 2'd1) : 2'd0;
    w0_o       = (size_i == SZ_BYTE) ? {2{wdata_i[7:0]}} : wdata_i[15:0];
    w1_o       = wdata_i[31:16];
    sc_we_o    = req_i & we_i & ~alt_i & ((addr_i == 3'd2) | split);
    sc_val_o   = split ? wdata_i[23:16] : wdata_i[7:0];
    cmd_we_o   = req_i & we_i & ~alt_i & (addr_i == 3'd7);
    cmd_val_o  = wdata_i[7:0];
    stat_clr_o = req_i & ~we_i & ~alt_i & (addr_i == 3'd7);
  end
endmodule

// File: rtl/ata_sector_buf.sv
module ata_sector_buf #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a0_i,
  input  logic [AW-1:0] a1_i,
  input  logic          we0_i,
  input  logic          we1_i,
  input  logic [15:0]   d0_i,
  input  logic [15:0]   d1_i,
  output logic [15:0]   q0_o,
  output logic [15:0]   q1_o,
  input  logic [AW-1:0] ma_i,
  input  logic          mwe_i,
  input  logic [15:0]   md_i,
  output logic [15:0]   mq_o
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we0_i) mem[a0_i] <= d0_i;
    if (we1_i) mem[a1_i] <= d1_i;
    if (mwe_i) mem[ma_i] <= md_i;
  end

  assign q0_o = mem[a0_i];
  assign q1_o = mem[a1_i];
  assign mq_o = mem[ma_i];

  // second lane only ever moves with the first
  assert_dword_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we1_i |-> we0_i);
endmodule

// File: rtl/ata_busy_timer.sv
module ata_busy_timer #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] load_i,
  output logic          active_o,
  output logic          done_o
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt      <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt      <= load_i;
    end else if (active_o) begin
      if (cnt == '0) active_o <= 1'b0;
      else           cnt      <= cnt - 1'b1;
    end
  end

  assign done_o = active_o & (cnt == '0);

  assert_timer_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !done_o) |=> active_o);
endmodule

// File: rtl/ata_pio_port.sv
module ata_pio_port
  import ata_pio_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MULT         = 4,
  parameter int DLY_W        = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               dev_present_i,
  input  logic                               mode32_i,
  input  logic [DLY_W-1:0]                   delay_i,
  input  logic                               req_i,
  input  logic                               we_i,
  input  logic                               alt_i,
  input  logic [2:0]                         addr_i,
  input  logic [1:0]                         size_i,
  input  logic [31:0]                        wdata_i,
  output logic [31:0]                        rdata_o,
  output logic                               irq_o,
  output logic                               med_fetch_o,
  output logic                               med_commit_o,
  input  logic [$clog2(SECTOR_BYTES/2)-1:0]  med_addr_i,
  input  logic                               med_we_i,
  input  logic [15:0]                        med_wdata_i,
  output logic [15:0]                        med_rdata_o
);
  localparam int WORDS = SECTOR_BYTES / 2;
  localparam int PW    = $clog2(WORDS);

  logic          bsy, drq;
  logic [PW-1:0] pos;
  logic [7:0]    secount, cmd, blk;
  op_e           op;
  logic [7:0]    stat;

  logic          data_acc, data_we, two, sc_we, cmd_we, stat_clr;
  logic [1:0]    adv;
  logic [15:0]   w0, w1, q0, q1, rd0, rd1;
  logic [7:0]    sc_val, cmd_val;
  logic [PW:0]   pos_sum;
  logic          wrap, last, blk_full, is_rd_cmd, is_wr_cmd, cmd_acc;
  logic          tmr_start, tmr_done, tmr_active;

  ata_host_decode u_dec (
    .req_i(req_i), .we_i(we_i), .alt_i(alt_i), .addr_i(addr_i), .size_i(size_i),
    .wdata_i(wdata_i), .mode32_i(mode32_i), .present_i(dev_present_i), .drq_i(drq),
    .data_acc_o(data_acc), .data_we_o(data_we), .two_o(two), .adv_o(adv),
    .w0_o(w0), .w1_o(w1), .sc_we_o(sc_we), .sc_val_o(sc_val),
    .cmd_we_o(cmd_we), .cmd_val_o(cmd_val), .stat_clr_o(stat_clr)
  );

  ata_sector_buf #(.WORDS(WORDS)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a0_i(pos), .a1_i(PW'(pos + 1'b1)),
    .we0_i(data_we), .we1_i(data_we & two), .d0_i(w0), .d1_i(w1),
    .q0_o(q0), .q1_o(q1),
    .ma_i(med_addr_i), .mwe_i(med_we_i), .md_i(med_wdata_i), .mq_o(med_rdata_o)
  );

  ata_busy_timer #(.DW(DLY_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start), .load_i(delay_i),
    .active_o(tmr_active), .done_o(tmr_done)
  );

  always_comb begin
    pos_sum   = {1'b0, pos} + (PW+1)'(adv);
    wrap      = data_acc & pos_sum[PW];
    last      = (secount == 8'd1);
    blk_full  = (int'(blk) + 1) >= MULT;
    is_rd_cmd = (cmd_val == CMD_RD) || (cmd_val == CMD_RD_MULT);
    is_wr_cmd = (cmd_val == CMD_WR) || (cmd_val == CMD_WR_MULT);
    cmd_acc   = cmd_we & dev_present_i & ~bsy;
    tmr_start = 1'b0;
    if (cmd_acc) tmr_start = is_rd_cmd;
    else if (wrap) begin
      if (op == OP_READ)  tmr_start = ~last;
      if (op == OP_WRITE) tmr_start = (cmd != CMD_WR_MULT) | blk_full | last;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsy <= 1'b0; drq <= 1'b0; irq_o <= 1'b0;
      pos <= '0; secount <= 8'd1; cmd <= 8'h00; blk <= 8'd0; op <= OP_NONE;
      med_fetch_o <= 1'b0; med_commit_o <= 1'b0;
    end else begin
      med_fetch_o  <= 1'b0;
      med_commit_o <= 1'b0;
      if (stat_clr) irq_o <= 1'b0;
      if (sc_we) secount <= sc_val;
      if (cmd_acc) begin
        cmd <= cmd_val; pos <= '0; blk <= 8'd0; irq_o <= 1'b0;
        if (is_rd_cmd) begin
          op <= OP_READ; bsy <= 1'b1; drq <= 1'b0; med_fetch_o <= 1'b1;
        end else if (is_wr_cmd) begin
          op <= OP_WRITE; drq <= 1'b1;
        end else begin
          op <= OP_NONE; drq <= 1'b0; irq_o <= 1'b1;  // no-data command
        end
      end else if (data_acc) begin
        pos <= pos_sum[PW-1:0];
        if (wrap) begin
          secount <= secount - 8'd1;
          if (op == OP_READ) begin
            drq <= 1'b0;
            blk <= blk_full ? 8'd0 : blk + 8'd1;
            if (!last) begin bsy <= 1'b1; med_fetch_o <= 1'b1; end
            else op <= OP_NONE;
          end else if (op == OP_WRITE) begin
            med_commit_o <= 1'b1;
            if (tmr_start) begin bsy <= 1'b1; drq <= 1'b0; blk <= 8'd0; end
            else blk <= blk + 8'd1;
          end
        end
      end else if (tmr_done) begin
        bsy <= 1'b0;
        if (op == OP_READ) begin
          drq <= 1'b1;
          if (cmd != CMD_RD_MULT || blk == 8'd0) irq_o <= 1'b1;
        end else if (op == OP_WRITE) begin
          irq_o <= 1'b1;
          drq   <= (secount != 8'd0);
          if (secount == 8'd0) op <= OP_NONE;
        end
      end
    end
  end

  always_comb begin
    stat          = 8'h00;
    stat[ST_BSY]  = bsy;
    stat[ST_DRDY] = dev_present_i & ~bsy;
    stat[ST_DRQ]  = drq;
    rd0 = dev_present_i ? q0 : ABSENT_WORD;
    rd1 = dev_present_i ? q1 : ABSENT_WORD;
    rdata_o = 32'h0;
    if (alt_i) rdata_o = {24'h0, stat};
    else begin
      case (addr_i)
        3'd0: begin
          if (size_i == SZ_BYTE)      rdata_o = {24'h0, rd0[7:0]};
          else if (size_i == SZ_WORD) rdata_o = {16'h0, rd0};
          else if (mode32_i)          rdata_o = {rd1, rd0};
          else                        rdata_o = {8'h00, secount, rd0};
        end
        3'd2: rdata_o = {24'h0, secount};
        3'd7: rdata_o = (size_i == SZ_BYTE) ? {24'h0, stat} : {16'h0, 8'hFF, stat};
        default: rdata_o = 32'h0;
      endcase
    end
  end

  assert_bsy_drq_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bsy && drq));
  assert_word_adv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && !two && !wrap) |=> (pos == PW'($past(pos) + 1'b1)));
  assert_alt_keeps_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && alt_i && !we_i && irq_o) |=> irq_o);
  assert_absent_no_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !alt_i && addr_i == 3'd0 && !dev_present_i) |=> (pos == $past(pos)));
  assert_rd_count_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && op == OP_READ && !sc_we) |=> (secount == 8'($past(secount) - 8'd1)));
  assert_busy_timer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsy |-> tmr_active);
endmodule

// File: tb/sim_ata_pio_port.sv
module sim_ata_pio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        present = 1'b1, mode32 = 1'b0;
  logic [15:0] delay = 16'd3;
  logic        req = 1'b0, we = 1'b0, alt = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = 32'h0, rdata;
  logic        irq, fetch, commit;
  logic [7:0]  med_addr = 8'd0;
  logic        med_we = 1'b0;
  logic [15:0] med_wdata = 16'h0, med_rdata;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  ata_pio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_present_i(present), .mode32_i(mode32),
    .delay_i(delay), .req_i(req), .we_i(we), .alt_i(alt), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .med_fetch_o(fetch), .med_commit_o(commit), .med_addr_i(med_addr),
    .med_we_i(med_we), .med_wdata_i(med_wdata), .med_rdata_o(med_rdata)
  );

  // {size, wdata, expected low word, expected high word}
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'h0000_00A5, 16'hA5A5, 16'h0000},
    {2'd1, 32'h0000_1234, 16'h1234, 16'h0000},
    {2'd2, 32'hBEEF_CAFE, 16'hCAFE, 16'hBEEF},
    {2'd0, 32'h0000_003C, 16'h3C3C, 16'h0000},
    {2'd1, 32'hFFFF_0001, 16'h0001, 16'h0000},
    {2'd2, 32'h0102_0304, 16'h0304, 16'h0102},
    {2'd0, 32'h0000_0000, 16'h0000, 16'h0000},
    {2'd1, 32'h0000_8000, 16'h8000, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sz, input logic w, input logic [2:0] a,
                     input logic [31:0] d, input logic al, output logic [31:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d; alt = al;
    #1 q = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0; alt = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] q;
    acc(sz, 1'b1, a, d, 1'b0, q);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [2:0] a, output logic [31:0] q);
    acc(sz, 1'b0, a, 32'h0, 1'b0, q);
  endtask

  task automatic alt_rd(output logic [31:0] q);
    acc(2'd0, 1'b0, 3'd0, 32'h0, 1'b1, q);
  endtask

  task automatic wait_ready(output int n, output logic [31:0] q);
    n = 0;
    forever begin
      alt_rd(q);
      if (!q[7] || n > 3000) break;
      n++;
    end
  endtask

  task automatic fill(input logic [7:0] tag);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      med_we = 1'b1; med_addr = 8'(i); med_wdata = {tag, 8'(i)};
    end
    @(negedge clk);
    med_we = 1'b0;
  endtask

  task automatic med_peek(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    med_addr = a;
    #1 v = med_rdata;
  endtask

  task automatic wr_words(input int n);
    for (int i = 0; i < n; i++) wr(2'd1, 3'd0, 32'(i));
  endtask

  task automatic rd_words(input int n);
    logic [31:0] q;
    for (int i = 0; i < n; i++) rd(2'd1, 3'd0, q);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] q;
    logic [15:0] v;
    int n, widx;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    alt_rd(q);           check("R12 status", q, 32'h40);
    check("R12 irq", {31'h0, irq}, 32'h0);
    rd(2'd0, 3'd2, q);   check("R12 count", q, 32'h01);

    // R10 single write, vectors from table
    wr(2'd0, 3'd2, 32'h1);
    wr(2'd0, 3'd7, 32'h30);
    alt_rd(q);           check("R10 write drq no busy", q, 32'h48);
    check("R10 no irq at start", {31'h0, irq}, 32'h0);
    mode32 = 1'b1;
    widx = 0;
    foreach (VEC[k]) begin
      wr(VEC[k][65:64], 3'd0, VEC[k][63:32]);
      widx += (VEC[k][65:64] == 2'd2) ? 2 : 1;
    end
    for (int i = widx; i < 256; i++) wr(2'd1, 3'd0, 32'(i));
    check("R10 commit pulse", {31'h0, commit}, 32'h1);
    alt_rd(q);           check("R2 busy after write sector", q, 32'h80);
    wait_ready(n, q);
    check("R10 done status", q, 32'h40);
    check("R10 irq after busy", {31'h0, irq}, 32'h1);
    widx = 0;
    foreach (VEC[k]) begin
      med_peek(8'(widx), v); check("R3 R5 table low word", {16'h0, v}, {16'h0, VEC[k][31:16]});
      widx++;
      if (VEC[k][65:64] == 2'd2) begin
        med_peek(8'(widx), v); check("R5 table high word", {16'h0, v}, {16'h0, VEC[k][15:0]});
        widx++;
      end
    end
    med_peek(8'd200, v); check("R1 word placement", {16'h0, v}, 32'd200);

    // R7 status word read clears irq
    rd(2'd1, 3'd7, q);   check("R7 word status", q, 32'h0000_FF40);
    check("R7 irq cleared", {31'h0, irq}, 32'h0);

    // R2 R11 read sector timing and mixed-width reads
    mode32 = 1'b0; delay = 16'd5;
    wr(2'd0, 3'd2, 32'h2);
    wr(2'd0, 3'd7, 32'h20);
    check("R11 fetch pulse on command", {31'h0, fetch}, 32'h1);
    wait_ready(n, q);
    check("R2 busy length", 32'(n), 32'd6);
    check("R2 drq after busy", q, 32'h48);
    check("R2 irq after busy", {31'h0, irq}, 32'h1);
    alt_rd(q);           check("R8 alt status value", q, 32'h48);
    check("R8 irq kept", {31'h0, irq}, 32'h1);
    rd(2'd1, 3'd0, q);   check("R1 word read", q, 32'hA5A5);
    rd(2'd0, 3'd0, q);   check("R4 byte read low", q, 32'h34);
    rd(2'd1, 3'd0, q);   check("R4 advanced by word", q, 32'hCAFE);
    mode32 = 1'b1;
    rd(2'd2, 3'd0, q);   check("R5 paired dword", q, 32'h3C3C_BEEF);
    mode32 = 1'b0;
    rd(2'd2, 3'd0, q);   check("R5 split dword", q, 32'h0002_0001);
    delay = 16'd300;
    for (int i = 6; i < 256; i++) begin
      rd(2'd1, 3'd0, q);
      if (i == 9)   check("R1 word 9", q, 32'h8000);
      if (i == 255) check("R1 word 255", q, 32'h00FF);
    end
    check("R11 fetch pulse on wrap", {31'h0, fetch}, 32'h1);
    rd(2'd0, 3'd2, q);   check("R9 count decremented", q, 32'h01);
    alt_rd(q);           check("R2 busy after wrap", q, 32'h80);
    fill(8'h02);
    wait_ready(n, q);
    check("R9 second sector ready", q, 32'h48);
    for (int i = 0; i < 256; i++) begin
      rd(2'd1, 3'd0, q);
      if (i == 0)   check("R11 media word 0", q, 32'h0200);
      if (i == 255) check("R11 media word 255", q, 32'h02FF);
    end
    alt_rd(q);           check("R9 last sector no busy", q, 32'h40);
    rd(2'd0, 3'd2, q);   check("R9 count zero", q, 32'h00);

    // R9 count of zero means 256
    delay = 16'd3;
    wr(2'd0, 3'd2, 32'h0);
    wr(2'd0, 3'd7, 32'h20);
    wait_ready(n, q);
    rd_words(256);
    alt_rd(q);           check("R9 zero count continues", q, 32'h80);
    rd(2'd0, 3'd2, q);   check("R9 zero count wraps to 255", q, 32'hFF);
    wait_ready(n, q);
    wr(2'd0, 3'd7, 32'h00);
    alt_rd(q);           check("R9 other command ends transfer", q, 32'h40);

    // R6 absent device
    wr(2'd0, 3'd2, 32'h1);
    wr(2'd0, 3'd7, 32'h30);
    present = 1'b0;
    rd(2'd1, 3'd0, q);   check("R6 absent word", q, 32'hFF7F);
    rd(2'd0, 3'd0, q);   check("R6 absent byte", q, 32'h7F);
    mode32 = 1'b1;
    rd(2'd2, 3'd0, q);   check("R6 absent dword", q, 32'hFF7F_FF7F);
    mode32 = 1'b0;
    wr(2'd1, 3'd0, 32'hDEAD);
    present = 1'b1;
    med_peek(8'd0, v);   check("R6 write ignored", {16'h0, v}, 32'h0200);
    wr(2'd1, 3'd0, 32'h7777);
    med_peek(8'd0, v);   check("R6 position held", {16'h0, v}, 32'h7777);
    wr_words(255);
    wait_ready(n, q);

    // R10 write multiple: busy only at the last sector here
    wr(2'd0, 3'd2, 32'h3);
    wr(2'd0, 3'd7, 32'hC5);
    wr_words(256);
    check("R10 multi commit", {31'h0, commit}, 32'h1);
    alt_rd(q);           check("R10 multi no busy mid block", q, 32'h48);
    check("R10 multi no irq mid block", {31'h0, irq}, 32'h0);
    rd(2'd0, 3'd2, q);   check("R10 multi count", q, 32'h02);
    wr_words(256);
    alt_rd(q);           check("R10 multi second sector", q, 32'h48);
    wr_words(256);
    alt_rd(q);           check("R10 multi busy at last", q, 32'h80);
    wait_ready(n, q);
    check("R10 multi done", q, 32'h40);
    check("R10 multi irq", {31'h0, irq}, 32'h1);

    // R9 read multiple: irq only for first sector of block
    wr(2'd0, 3'd2, 32'h2);
    wr(2'd0, 3'd7, 32'hC4);
    wait_ready(n, q);
    check("R9 multi first irq", {31'h0, irq}, 32'h1);
    rd(2'd0, 3'd7, q);
    check("R7 byte status clears irq", {31'h0, irq}, 32'h0);
    rd_words(256);
    wait_ready(n, q);
    check("R9 multi second ready", q, 32'h48);
    check("R9 multi no irq inside block", {31'h0, irq}, 32'h0);
    rd_words(256);
    alt_rd(q);           check("R9 multi finished", q, 32'h40);

    summary();
  end
endmodule